// File: doc/BRIEF.md
# Gated Counter Channel

A single 16-bit timer channel that counts an incoming tick strobe and watches for two events: the count matching a programmable target, and the count reaching all-ones. Each event sets a sticky status flag. Either event can be enabled to drive an active-low interrupt line. The line is driven either as a short fixed-length pulse, or as a level that inverts on every enabled event. In pulse style the channel can fire once per configuration or on every event. Clock-source selection, any prescaler and address decoding live outside the block. The block sees a tick strobe that is already qualified and one-cycle strobes for each register access.

A gate input can control counting in one of four ways, selected by the control word:
- pause while the gate is high;
- free count with a clear on the gate's falling edge;
- clear on the rising edge and count only while the gate is high;
- count only while the gate is high until the gate first falls, after which gating switches itself off and counting runs freely.

All register effects take place on the clock edge that samples the strobe. They are visible on the outputs in the following cycle. `rst_n` is asserted asynchronously and is expected to be released synchronously by the reset network that feeds it.

Top module: `gate_timer_channel`

Mode word fields, by bit position:
- bit 0: gating on.
- bits 2:1: gating style, 0 to 3.
- bit 3: clear on target.
- bit 4: interrupt on target.
- bit 5: interrupt on overflow.
- bit 6: repeat.
- bit 7: toggle style.
- bits 9:8: source select. This field is stored only.
- bit 10: interrupt request level, active low.
- bit 11: target flag.
- bit 12: overflow flag.
- bits 15:13: read as 0.

## Requirements
- R1: After reset, `count_o` and `target_o` are 0, `mode_o` is 0x0400 and `irq_n_o` is 1.
- R2: A counter write stores the low 16 bits of `cnt_wdata_i`, and a target write stores the low 16 bits of `tgt_wdata_i`. A mode write stores only bits 9:0 of `mode_wdata_i`, and it also clears the counter to 0.
- R3: With gating off (bit 0 = 0), every cycle with `tick_i` high adds one to the counter.
- R4: Gating style 0 with bit 0 = 1: ticks are ignored while `gate_i` is high and counted while it is low.
- R5: Gating style 1: ticks are always counted, and a high-to-low transition of `gate_i` clears the counter.
- R6: Gating style 2: a low-to-high transition of `gate_i` clears the counter, and ticks are counted only while `gate_i` is high.
- R7: Gating style 3: ticks are counted only while `gate_i` is high. A high-to-low transition of `gate_i` clears bit 0 of the mode word, after which ticks are counted regardless of the gate.
- R8: The target match is evaluated on every counted tick, every counter write and every target write. A match occurs when the new count equals the (new) target. A match sets bit 11. If bit 3 = 1 and the target is nonzero, the counter becomes 0 instead of the matching value.
- R9: A count of 0xFFFF sets bit 12 and is replaced by 0 in the same cycle, so `count_o` never shows 0xFFFF.
- R10: A cycle with `mode_re_i` high clears bits 11 and 12 for the next cycle. `mode_o` shows the flags unchanged during that read cycle, and a new event in the same cycle keeps its flag set.
- R11: Pulse style (bit 7 = 0): an enabled event (target with bit 4, overflow with bit 5) drives `irq_n_o` low for exactly 3 cycles while bit 10 stays 1. With bit 6 = 0, only the first enabled event after a mode write pulses.
- R12: Toggle style (bit 7 = 1): each enabled event inverts bit 10, and `irq_n_o` equals bit 10.
- R13: A mode write sets bit 10 to 1, releases `irq_n_o` high, cancels a running pulse and re-arms the single-shot pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tick_i | input | 1 | Count strobe, one count per high cycle |
| gate_i | input | 1 | Gate level used by the gating styles |
| mode_we_i | input | 1 | Mode word write strobe |
| mode_wdata_i | input | 16 | Mode write data, bits 9:0 used |
| mode_re_i | input | 1 | Mode word read strobe, clears the flags |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 32 | Counter write data, low 16 bits used |
| tgt_we_i | input | 1 | Target write strobe |
| tgt_wdata_i | input | 32 | Target write data, low 16 bits used |
| count_o | output | 16 | Current count |
| mode_o | output | 16 | Mode and status word |
| target_o | output | 16 | Current target |
| irq_n_o | output | 1 | Interrupt line, active low |

## Verification
The bench targets these cases, and for each it names the failure a wrong design would show:
- Clear-on-target at the target value: a design that compared with greater-or-equal, or cleared one cycle late, would show the target value on `count_o`.
- The all-ones count: a design that let it stand for one cycle would show 0xFFFF.
- Each gating style's edge behaviour: a wrong design would clear on the wrong gate edge, or keep gating after the self-disabling style's falling edge.
- The single-shot pulse: a design that did not latch the shot would pulse a second time before the next mode write, and a wrong pulse counter would hold the line low for a length other than three cycles.
- Toggle style and flag clearing: a wrong design would leave the interrupt level stuck, or clear the flags in the read cycle itself instead of after it.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  typedef enum logic [1:0] {
    SYNC_PAUSE_HI = 2'd0,
    SYNC_CLR_FALL = 2'd1,
    SYNC_CLR_RISE = 2'd2,
    SYNC_ONCE     = 2'd3
  } sync_kind_e;

  localparam int unsigned MODE_W    = 16;
  localparam int unsigned CTL_W     = 10;
  localparam int unsigned B_SYNC_EN = 0;
  localparam int unsigned B_KIND_LO = 1;
  localparam int unsigned B_RST_TGT = 3;
  localparam int unsigned B_IRQ_TGT = 4;
  localparam int unsigned B_IRQ_OVF = 5;
  localparam int unsigned B_REPEAT  = 6;
  localparam int unsigned B_TOGGLE  = 7;
endpackage

// File: rtl/gtc_gate.sv
module gtc_gate
  import gtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate_i,
  input  logic       sync_en_i,
  input  logic [1:0] kind_i,
  output logic       run_o,
  output logic       clr_o,
  output logic       drop_o
);
  logic gate_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_i;
  end

  always_comb begin
    rise   = gate_i & ~gate_q;
    fall   = ~gate_i & gate_q;
    run_o  = 1'b1;
    clr_o  = 1'b0;
    drop_o = 1'b0;
    if (sync_en_i) begin
      unique case (sync_kind_e'(kind_i))
        SYNC_PAUSE_HI: run_o = ~gate_i;
        SYNC_CLR_FALL: clr_o = fall;
        SYNC_CLR_RISE: begin
          run_o = gate_i;
          clr_o = rise;
        end
        SYNC_ONCE: begin
          run_o  = gate_i;
          drop_o = fall;
        end
        default: run_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/gtc_irq.sv
module gtc_irq #(
  parameter int unsigned PULSE_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic event_i,
  input  logic toggle_i,
  input  logic repeat_i,
  output logic req_n_o,
  output logic irq_n_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic          req_n_q, req_n_d;
  logic          done_q, done_d;
  logic [PW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    req_n_d = req_n_q;
    done_d  = done_q;
    pcnt_d  = (pcnt_q != '0) ? pcnt_q - 1'b1 : '0;
    if (clr_i) begin
      req_n_d = 1'b1;
      done_d  = 1'b0;
      pcnt_d  = '0;
    end else if (event_i) begin
      if (toggle_i) begin
        req_n_d = ~req_n_q;
      end else begin
        req_n_d = 1'b1;
        done_d  = 1'b1;
        if (!done_q || repeat_i) pcnt_d = PW'(PULSE_LEN);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_n_q <= 1'b1;
      done_q  <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      req_n_q <= req_n_d;
      done_q  <= done_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign req_n_o = req_n_q;
  assign irq_n_o = req_n_q & (pcnt_q == '0);

  p_pulse_level_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !toggle_i |-> req_n_q);
  p_single_shot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (event_i && !toggle_i && done_q && !repeat_i && !clr_i && pcnt_q == '0) |=> irq_n_o);
  p_release_r13: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> irq_n_o);
endmodule

// File: rtl/gate_timer_channel.sv
module gate_timer_channel
  import gtc_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned WD_W      = 32,
  parameter int unsigned PULSE_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              gate_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              mode_re_i,
  input  logic              cnt_we_i,
  input  logic [WD_W-1:0]   cnt_wdata_i,
  input  logic              tgt_we_i,
  input  logic [WD_W-1:0]   tgt_wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [CNT_W-1:0]  target_o,
  output logic              irq_n_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, tgt_q, tgt_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             tflag_q, tflag_d, oflag_q, oflag_d;
  logic             run, gclr, drop, req_n;
  logic [CNT_W-1:0] base, raw, reduced;
  logic             inc, eval, hit_t, hit_o, irq_ev;

  gtc_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_i    (gate_i),
    .sync_en_i (ctl_q[B_SYNC_EN]),
    .kind_i    (ctl_q[B_KIND_LO +: 2]),
    .run_o     (run),
    .clr_o     (gclr),
    .drop_o    (drop)
  );

  always_comb begin
    base    = gclr ? '0 : cnt_q;
    inc     = tick_i & run;
    raw     = cnt_we_i ? cnt_wdata_i[CNT_W-1:0] : base + CNT_W'(inc);
    tgt_d   = tgt_we_i ? tgt_wdata_i[CNT_W-1:0] : tgt_q;
    eval    = (cnt_we_i | tgt_we_i | inc) & ~mode_we_i;
    hit_t   = eval & (raw == tgt_d);
    reduced = (hit_t & ctl_q[B_RST_TGT] & (tgt_d != '0)) ? '0 : raw;
    hit_o   = eval & (reduced == ALL_ONES);
    cnt_d   = (mode_we_i | hit_o) ? '0 : reduced;
    ctl_d   = ctl_q;
    if (mode_we_i)  ctl_d = mode_wdata_i[CTL_W-1:0];
    else if (drop)  ctl_d[B_SYNC_EN] = 1'b0;
    tflag_d = (tflag_q & ~mode_re_i) | hit_t;
    oflag_d = (oflag_q & ~mode_re_i) | hit_o;
    irq_ev  = (hit_t & ctl_q[B_IRQ_TGT]) | (hit_o & ctl_q[B_IRQ_OVF]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tgt_q   <= '0;
      ctl_q   <= '0;
      tflag_q <= 1'b0;
      oflag_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      tgt_q   <= tgt_d;
      ctl_q   <= ctl_d;
      tflag_q <= tflag_d;
      oflag_q <= oflag_d;
    end
  end

  gtc_irq #(.PULSE_LEN(PULSE_LEN)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (mode_we_i),
    .event_i  (irq_ev),
    .toggle_i (ctl_q[B_TOGGLE]),
    .repeat_i (ctl_q[B_REPEAT]),
    .req_n_o  (req_n),
    .irq_n_o  (irq_n_o)
  );

  assign count_o  = cnt_q;
  assign target_o = tgt_q;
  assign mode_o   = MODE_W'({oflag_q, tflag_q, req_n, ctl_q});

  p_never_all_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count_o != ALL_ONES);
  p_pause_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[B_SYNC_EN] && ctl_q[2:1] == 2'd0 && gate_i && !mode_we_i && !cnt_we_i && !tgt_we_i)
      |=> $stable(count_o));
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o[11] && !mode_re_i) |=> mode_o[11]);
  p_mode_write_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we_i |=> (count_o == '0));
endmodule

// File: tb/sim_gate_timer_channel.sv
module sim_gate_timer_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i, gate_i, mode_we_i, mode_re_i, cnt_we_i, tgt_we_i;
  logic [15:0] mode_wdata_i;
  logic [31:0] cnt_wdata_i, tgt_wdata_i;
  logic [15:0] count_o, mode_o, target_o;
  logic        irq_n_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  gate_timer_channel u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_i(gate_i),
    .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i), .mode_re_i(mode_re_i),
    .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
    .tgt_we_i(tgt_we_i), .tgt_wdata_i(tgt_wdata_i),
    .count_o(count_o), .mode_o(mode_o), .target_o(target_o), .irq_n_o(irq_n_o)
  );

  localparam logic [1:0] OP_MODE = 2'd0, OP_CNT = 2'd1, OP_TGT = 2'd2, OP_TICK = 2'd3;
  localparam int NV = 13;
  // {op, data, expected count after the op}
  localparam logic [33:0] VEC [NV] = '{
    {OP_MODE, 16'h0008, 16'h0000},
    {OP_TGT,  16'h0005, 16'h0000},
    {OP_CNT,  16'h0003, 16'h0003},
    {OP_TICK, 16'h0000, 16'h0004},
    {OP_TICK, 16'h0000, 16'h0000},
    {OP_TICK, 16'h0000, 16'h0001},
    {OP_CNT,  16'hFFFE, 16'hFFFE},
    {OP_TICK, 16'h0000, 16'h0000},
    {OP_MODE, 16'h0000, 16'h0000},
    {OP_TICK, 16'h0000, 16'h0001},
    {OP_TGT,  16'h0002, 16'h0001},
    {OP_TICK, 16'h0000, 16'h0002},
    {OP_TICK, 16'h0000, 16'h0003}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [31:0] data);
    @(negedge clk);
    unique case (op)
      OP_MODE: begin mode_we_i = 1'b1; mode_wdata_i = data[15:0]; end
      OP_CNT:  begin cnt_we_i = 1'b1; cnt_wdata_i = data; end
      OP_TGT:  begin tgt_we_i = 1'b1; tgt_wdata_i = data; end
      default: tick_i = 1'b1;
    endcase
    @(negedge clk);
    mode_we_i = 1'b0; cnt_we_i = 1'b0; tgt_we_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic set_gate(input logic v);
    @(negedge clk);
    gate_i = v;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; gate_i = 1'b0; mode_we_i = 1'b0; mode_re_i = 1'b0;
    cnt_we_i = 1'b0; tgt_we_i = 1'b0; mode_wdata_i = '0; cnt_wdata_i = '0; tgt_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", 32'(count_o), 0);
    chk("R1 target", 32'(target_o), 0);
    chk("R1 mode", 32'(mode_o), 32'h0400);
    chk("R1 irq", 32'(irq_n_o), 1);

    // R3 R8 R9: vector walk with gating off
    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][33:32], 32'(VEC[i][31:16]));
      chk($sformatf("R3 R8 R9 row %0d", i), 32'(count_o), 32'(VEC[i][15:0]));
    end

    // R10: flags visible during the read, cleared after
    chk("R8 target flag", 32'(mode_o[11]), 1);
    chk("R9 overflow flag", 32'(mode_o[12]), 1);
    @(negedge clk);
    mode_re_i = 1'b1;
    #1 chk("R10 flags during read", 32'(mode_o[12:11]), 3);
    @(negedge clk);
    mode_re_i = 1'b0;
    chk("R10 flags after read", 32'(mode_o[12:11]), 0);

    // R2: truncation and mode write mask
    do_op(OP_CNT, 32'hABCD_1234);
    chk("R2 counter low bits", 32'(count_o), 32'h1234);
    do_op(OP_TGT, 32'h0007_7777);
    chk("R2 target low bits", 32'(target_o), 32'h7777);
    do_op(OP_MODE, 32'h0000_FFFF);
    chk("R2 mode mask", 32'(mode_o), 32'h07FF);
    chk("R2 mode write clears count", 32'(count_o), 0);

    // R11: pulse style, single shot then repeat
    do_op(OP_MODE, 32'h0010);
    do_op(OP_TGT, 3);
    do_op(OP_CNT, 2);
    do_op(OP_TICK, 0);
    chk("R11 pulse cycle 1", 32'(irq_n_o), 0);
    chk("R11 level bit stays 1", 32'(mode_o[10]), 1);
    @(negedge clk); chk("R11 pulse cycle 2", 32'(irq_n_o), 0);
    @(negedge clk); chk("R11 pulse cycle 3", 32'(irq_n_o), 0);
    @(negedge clk); chk("R11 pulse ends", 32'(irq_n_o), 1);
    do_op(OP_CNT, 2);
    do_op(OP_TICK, 0);
    chk("R11 single shot no pulse", 32'(irq_n_o), 1);
    @(negedge clk); chk("R11 single shot still high", 32'(irq_n_o), 1);
    do_op(OP_MODE, 32'h0050);
    do_op(OP_CNT, 2);
    do_op(OP_TICK, 0);
    chk("R11 repeat pulse 1", 32'(irq_n_o), 0);
    repeat (3) @(negedge clk);
    do_op(OP_CNT, 2);
    do_op(OP_TICK, 0);
    chk("R11 repeat pulse 2", 32'(irq_n_o), 0);
    repeat (3) @(negedge clk);

    // R12 toggle style, R13 release on mode write
    do_op(OP_MODE, 32'h0090);
    chk("R12 toggle start", 32'(irq_n_o), 1);
    do_op(OP_CNT, 2);
    do_op(OP_TICK, 0);
    chk("R12 toggle low", 32'(irq_n_o), 0);
    chk("R12 level bit low", 32'(mode_o[10]), 0);
    repeat (4) @(negedge clk);
    chk("R12 toggle holds", 32'(irq_n_o), 0);
    do_op(OP_CNT, 2);
    do_op(OP_TICK, 0);
    chk("R12 toggle back high", 32'(irq_n_o), 1);
    do_op(OP_CNT, 2);
    do_op(OP_TICK, 0);
    chk("R12 toggle low again", 32'(irq_n_o), 0);
    do_op(OP_MODE, 32'h0090);
    chk("R13 mode write releases line", 32'(irq_n_o), 1);
    chk("R13 level bit set", 32'(mode_o[10]), 1);

    // R4: pause while gate high
    set_gate(1'b1);
    do_op(OP_MODE, 32'h0001);
    do_op(OP_TICK, 0);
    chk("R4 paused", 32'(count_o), 0);
    set_gate(1'b0);
    do_op(OP_TICK, 0);
    chk("R4 counts gate low", 32'(count_o), 1);

    // R5: clear on gate fall
    do_op(OP_MODE, 32'h0003);
    do_op(OP_TICK, 0);
    chk("R5 counts gate low", 32'(count_o), 1);
    set_gate(1'b1);
    do_op(OP_TICK, 0);
    chk("R5 counts gate high", 32'(count_o), 2);
    set_gate(1'b0);
    chk("R5 cleared on fall", 32'(count_o), 0);

    // R6: clear on rise, count while high
    do_op(OP_MODE, 32'h0005);
    do_op(OP_TICK, 0);
    chk("R6 idle gate low", 32'(count_o), 0);
    do_op(OP_CNT, 7);
    set_gate(1'b1);
    chk("R6 cleared on rise", 32'(count_o), 0);
    do_op(OP_TICK, 0);
    chk("R6 counts gate high", 32'(count_o), 1);
    set_gate(1'b0);
    do_op(OP_TICK, 0);
    chk("R6 no clear on fall, halted", 32'(count_o), 1);

    // R7: gated once, then free
    do_op(OP_MODE, 32'h0007);
    do_op(OP_TICK, 0);
    chk("R7 idle before gate", 32'(count_o), 0);
    set_gate(1'b1);
    do_op(OP_TICK, 0);
    chk("R7 counts gate high", 32'(count_o), 1);
    set_gate(1'b0);
    chk("R7 gating bit dropped", 32'(mode_o[0]), 0);
    do_op(OP_TICK, 0);
    chk("R7 free run gate low", 32'(count_o), 2);

    ended = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule